// File: doc/BRIEF.md
# Offset Register Load and Readback Sequencer

This block holds the two threshold offsets that a synchronous FIFO's partial-flag logic compares against: the almost-empty offset `n` and the almost-full offset `m`. Both are loaded over the FIFO's ordinary data input and can be read back over a dedicated output. A load-select input turns the write and read enables into offset accesses, so no extra address pins are needed. A single alternating pointer chooses the target register.

Loads happen on the write clock. Each qualified edge stores the low 12 data bits into the register the write pointer selects, then moves the pointer to the other register. Readback happens on the read clock and uses its own alternating pointer. Both pointers keep their position while load-select is low, so a sequence can be paused and resumed without starting over. Readback works only in standard timing mode; in fall-through mode a readback request is ignored.

While load-select is high, the normal FIFO data write and read are blocked. The block reports this through two gate outputs. The offsets go to the flag logic cut down to the FIFO's pointer width. The control and status pins are plain level signals. No valid/ready handshake is involved: an offset access is taken on every qualified edge and cannot be back-pressured.

Top module: `ofs_seq`

## Requirements
- R1: After reset, `ofs_n` and `ofs_m` both equal the depth's default offset: 31 for a depth up to 256, 63 up to 512, and 127 above that. Both the write pointer and the read pointer select the empty offset, `ofs_q` is 0 and `ofs_q_vld` is low.
- R2: On each rising `wclk` with `ld_sel` and `wr_en` both high, `din[11:0]` is stored into the register the write pointer selects. The order of targets is empty offset, full offset, empty offset, and so on.
- R3: When `ld_sel` is low, or `wr_en` is low, no offset changes and the write pointer holds its position. The next load continues with the register that follows the last one written.
- R4: On each rising `rclk` with `ld_sel` and `rd_en` both high and `fwft_mode` low, `ofs_q` takes the offset the read pointer selects (empty first, then full, alternating). `ofs_q_vld` is high for the cycle that follows.
- R5: While `fwft_mode` is high, a readback request is ignored. `ofs_q_vld` stays low, `ofs_q` holds its value and the read pointer does not advance.
- R6: `fifo_wr_ok` equals `wr_en` and `fifo_rd_ok` equals `rd_en` whenever `ld_sel` is low. Both are low whenever `ld_sel` is high.
- R7: `ofs_n` and `ofs_m` carry the low log2(DEPTH) bits of the stored 12-bit offsets. Readback returns all 12 stored bits.
- R8: Data bits above bit 11 of `din` have no effect on the stored offsets.
- R9: When a load and a readback of the same register fall on the same edge (shared clocks), the readback returns the value held before that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-domain clock |
| rclk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| fwft_mode | input | 1 | 1 = fall-through timing (readback disabled), 0 = standard |
| ld_sel | input | 1 | High: enables address the offset registers |
| wr_en | input | 1 | Write enable (write domain) |
| rd_en | input | 1 | Read enable (read domain) |
| din | input | DATA_W | FIFO data input; bits 11:0 carry offsets |
| ofs_n | output | AW | Almost-empty offset to flag logic |
| ofs_m | output | AW | Almost-full offset to flag logic |
| ofs_q | output | OFS_W | Offset readback value |
| ofs_q_vld | output | 1 | ofs_q was updated on the last rclk edge |
| fifo_wr_ok | output | 1 | Normal data write permitted |
| fifo_rd_ok | output | 1 | Normal data read permitted |

## Verification
An offset load and an offset readback can land on the same edge and target the same register. The bench forces this by aligning both pointers on the full offset and then raising `ld_sel`, `wr_en` and `rd_en` together on a shared clock. Two results are judged: `ofs_q` must show the old full offset, and `ofs_m` must show the new one. A further read then confirms that each pointer stepped exactly once.

// File: rtl/ofs_seq_pkg.sv
package ofs_seq_pkg;
  typedef enum logic {SEL_EMPTY = 1'b0, SEL_FULL = 1'b1} ofs_sel_e;

  function automatic int unsigned dflt_offset(input int unsigned depth);
    if (depth <= 256) return 31;
    else if (depth <= 512) return 63;
    else return 127;
  endfunction

  function automatic ofs_sel_e next_sel(input ofs_sel_e s);
    return (s == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
  endfunction
endpackage

// File: rtl/ofs_wr_seq.sv
module ofs_wr_seq
  import ofs_seq_pkg::*;
#(
  parameter int OFS_W = 12,
  parameter logic [OFS_W-1:0] DFLT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_sel,
  input  logic             wr_en,
  input  logic [OFS_W-1:0] din,
  output logic [OFS_W-1:0] empty_ofs,
  output logic [OFS_W-1:0] full_ofs
);
  ofs_sel_e wptr;
  logic     take;

  assign take = ld_sel && wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr      <= SEL_EMPTY;
      empty_ofs <= DFLT;
      full_ofs  <= DFLT;
    end else if (take) begin
      if (wptr == SEL_EMPTY) empty_ofs <= din;
      else                   full_ofs  <= din;
      wptr <= next_sel(wptr);
    end
  end
endmodule

// File: rtl/ofs_rd_seq.sv
module ofs_rd_seq
  import ofs_seq_pkg::*;
#(
  parameter int OFS_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_sel,
  input  logic             rd_en,
  input  logic             fwft_mode,
  input  logic [OFS_W-1:0] empty_ofs,
  input  logic [OFS_W-1:0] full_ofs,
  output logic [OFS_W-1:0] q,
  output logic             q_vld
);
  ofs_sel_e rptr;
  logic     take;

  assign take = ld_sel && rd_en && !fwft_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr  <= SEL_EMPTY;
      q     <= '0;
      q_vld <= 1'b0;
    end else begin
      q_vld <= take;
      if (take) begin
        q    <= (rptr == SEL_FULL) ? full_ofs : empty_ofs;
        rptr <= next_sel(rptr);
      end
    end
  end
endmodule

// File: rtl/ofs_seq.sv
module ofs_seq
  import ofs_seq_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 18,
  parameter int OFS_W  = 12
) (
  input  logic                       wclk,
  input  logic                       rclk,
  input  logic                       rst_n,
  input  logic                       fwft_mode,
  input  logic                       ld_sel,
  input  logic                       wr_en,
  input  logic                       rd_en,
  input  logic [DATA_W-1:0]          din,
  output logic [$clog2(DEPTH)-1:0]   ofs_n,
  output logic [$clog2(DEPTH)-1:0]   ofs_m,
  output logic [OFS_W-1:0]           ofs_q,
  output logic                       ofs_q_vld,
  output logic                       fifo_wr_ok,
  output logic                       fifo_rd_ok
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [OFS_W-1:0] DFLT = OFS_W'(dflt_offset(DEPTH));

  logic [OFS_W-1:0] empty_ofs, full_ofs;

  generate
    if (DATA_W > OFS_W) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^din[DATA_W-1:OFS_W];
    end
  endgenerate

  assign fifo_wr_ok = wr_en && !ld_sel;
  assign fifo_rd_ok = rd_en && !ld_sel;

  ofs_wr_seq #(.OFS_W(OFS_W), .DFLT(DFLT)) u_wr (
    .clk(wclk), .rst_n(rst_n), .ld_sel(ld_sel), .wr_en(wr_en),
    .din(din[OFS_W-1:0]), .empty_ofs(empty_ofs), .full_ofs(full_ofs)
  );

  ofs_rd_seq #(.OFS_W(OFS_W)) u_rd (
    .clk(rclk), .rst_n(rst_n), .ld_sel(ld_sel), .rd_en(rd_en),
    .fwft_mode(fwft_mode), .empty_ofs(empty_ofs), .full_ofs(full_ofs),
    .q(ofs_q), .q_vld(ofs_q_vld)
  );

  generate
    if (AW <= OFS_W) begin : g_trunc
      assign ofs_n = empty_ofs[AW-1:0];
      assign ofs_m = full_ofs[AW-1:0];
    end else begin : g_ext
      assign ofs_n = AW'(empty_ofs);
      assign ofs_m = AW'(full_ofs);
    end
  endgenerate
endmodule

// File: rtl/ofs_seq_chk.sv
module ofs_seq_chk #(
  parameter int AW = 8
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst_n,
  input logic          fwft_mode,
  input logic          ld_sel,
  input logic          wr_en,
  input logic          rd_en,
  input logic [AW-1:0] ofs_n,
  input logic [AW-1:0] ofs_m,
  input logic          ofs_q_vld,
  input logic          fifo_wr_ok,
  input logic          fifo_rd_ok
);
  // R2: a single load touches at most one offset
  a_r2_one_target: assert property (@(posedge wclk) disable iff (!rst_n)
    (ld_sel && wr_en) |=> ($stable(ofs_n) || $stable(ofs_m)));

  // R3: no load, no change
  a_r3_hold: assert property (@(posedge wclk) disable iff (!rst_n)
    !(ld_sel && wr_en) |=> ($stable(ofs_n) && $stable(ofs_m)));

  // R4: valid only after a qualified readback request
  a_r4_vld_cause: assert property (@(posedge rclk) disable iff (!rst_n)
    ofs_q_vld |-> $past(ld_sel && rd_en && !fwft_mode));

  // R5: fall-through mode never produces a readback
  a_r5_fwft_quiet: assert property (@(posedge rclk) disable iff (!rst_n)
    $past(fwft_mode) |-> !ofs_q_vld);

  // R6: load-select blocks normal data traffic
  a_r6_gate: assert property (@(posedge wclk) disable iff (!rst_n)
    ld_sel |-> (!fifo_wr_ok && !fifo_rd_ok));
endmodule

bind ofs_seq ofs_seq_chk #(.AW(AW)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .fwft_mode(fwft_mode),
  .ld_sel(ld_sel), .wr_en(wr_en), .rd_en(rd_en), .ofs_n(ofs_n),
  .ofs_m(ofs_m), .ofs_q_vld(ofs_q_vld), .fifo_wr_ok(fifo_wr_ok),
  .fifo_rd_ok(fifo_rd_ok)
);

// File: tb/ofs_seq_test.sv
`timescale 1ns/1ps
module ofs_seq_test;
  localparam int DEPTH = 256, DATA_W = 18, OFS_W = 12, AW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fwft_mode = 1'b0, ld_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [DATA_W-1:0] din = '0;
  logic [AW-1:0] ofs_n, ofs_m;
  logic [OFS_W-1:0] ofs_q;
  logic ofs_q_vld, fifo_wr_ok, fifo_rd_ok;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  ofs_seq #(.DEPTH(DEPTH), .DATA_W(DATA_W), .OFS_W(OFS_W)) uut (
    .wclk(clk), .rclk(clk), .rst_n(rst_n), .fwft_mode(fwft_mode),
    .ld_sel(ld_sel), .wr_en(wr_en), .rd_en(rd_en), .din(din),
    .ofs_n(ofs_n), .ofs_m(ofs_m), .ofs_q(ofs_q), .ofs_q_vld(ofs_q_vld),
    .fifo_wr_ok(fifo_wr_ok), .fifo_rd_ok(fifo_rd_ok)
  );

  // {din[17:0], expected n[7:0], expected m[7:0]}, loaded one at a time with gaps
  localparam logic [33:0] VEC [6] = '{
    {18'h00005, 8'd5,   8'd31},
    {18'h0000A, 8'd5,   8'd10},
    {18'h3F0C8, 8'd200, 8'd10},   // R8 upper bits set
    {18'h001FF, 8'd200, 8'hFF},   // R7 truncation of 0x1FF
    {18'h00003, 8'd3,   8'hFF},
    {18'h00040, 8'd3,   8'd64}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic load(input logic [DATA_W-1:0] d);
    @(negedge clk); ld_sel = 1'b1; wr_en = 1'b1; din = d;
    @(negedge clk); ld_sel = 1'b0; wr_en = 1'b0; din = '0;
  endtask

  task automatic rdback(input string req, input logic [OFS_W-1:0] exp, input logic exp_vld);
    @(negedge clk); ld_sel = 1'b1; rd_en = 1'b1;
    @(negedge clk); ld_sel = 1'b0; rd_en = 1'b0;
    chk({req, " vld"}, 32'(ofs_q_vld), 32'(exp_vld));
    chk({req, " q"}, 32'(ofs_q), 32'(exp));
  endtask

  initial begin
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #9; rst_n = 1'b1;
    @(negedge clk);
    chk("R1 n default", 32'(ofs_n), 32'd31);
    chk("R1 m default", 32'(ofs_m), 32'd31);
    chk("R1 vld", 32'(ofs_q_vld), 32'd0);
    chk("R1 q", 32'(ofs_q), 32'd0);

    for (int i = 0; i < 6; i++) begin
      load(VEC[i][33:16]);
      chk("R2/R3 n", 32'(ofs_n), 32'(VEC[i][15:8]));
      chk("R2/R3 m", 32'(ofs_m), 32'(VEC[i][7:0]));
      @(negedge clk);
    end

    // R6 and R3: data write without load-select leaves offsets alone
    @(negedge clk); wr_en = 1'b1; rd_en = 1'b1; din = 18'h00FFF; #1;
    chk("R6 wr_ok", 32'(fifo_wr_ok), 32'd1);
    chk("R6 rd_ok", 32'(fifo_rd_ok), 32'd1);
    ld_sel = 1'b1; wr_en = 1'b0; rd_en = 1'b0; #1;
    chk("R6 wr blocked", 32'(fifo_wr_ok), 32'd0);
    @(negedge clk); wr_en = 1'b1; rd_en = 1'b1; #1;
    chk("R6 wr blocked en", 32'(fifo_wr_ok), 32'd0);
    chk("R6 rd blocked en", 32'(fifo_rd_ok), 32'd0);
    ld_sel = 1'b0; wr_en = 1'b1; rd_en = 1'b0;
    @(negedge clk); wr_en = 1'b0; din = '0;
    chk("R3 n hold", 32'(ofs_n), 32'd3);
    chk("R3 m hold", 32'(ofs_m), 32'd64);

    // R4 readback, R7 full 12 bits
    rdback("R4 empty", 12'h003, 1'b1);
    rdback("R4 full", 12'h040, 1'b1);
    @(negedge clk);
    chk("R4 vld drop", 32'(ofs_q_vld), 32'd0);

    // R5 fall-through ignores readback
    fwft_mode = 1'b1;
    rdback("R5 ignored", 12'h040, 1'b0);
    fwft_mode = 1'b0;
    rdback("R5 ptr kept", 12'h003, 1'b1);

    // R9 same-edge load and readback of the full offset
    load(18'h00011);
    chk("R9 prep n", 32'(ofs_n), 32'h11);
    @(negedge clk); ld_sel = 1'b1; wr_en = 1'b1; rd_en = 1'b1; din = 18'h000AA;
    @(negedge clk); ld_sel = 1'b0; wr_en = 1'b0; rd_en = 1'b0; din = '0;
    chk("R9 old value", 32'(ofs_q), 32'h040);
    chk("R9 new m", 32'(ofs_m), 32'hAA);
    rdback("R9 rptr step", 12'h011, 1'b1);

    // R7 readback of an untruncated value
    load(18'h001FF);
    chk("R7 n trunc", 32'(ofs_n), 32'hFF);
    rdback("R7 full", 12'h0AA, 1'b1);
    rdback("R7 wide", 12'h1FF, 1'b1);

    // R1 reset mid-run restores defaults and pointers
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 rst n", 32'(ofs_n), 32'd31);
    chk("R1 rst m", 32'(ofs_m), 32'd31);
    rst_n = 1'b1;
    load(18'h00009);
    chk("R1 wptr empty", 32'(ofs_n), 32'd9);
    chk("R1 wptr m", 32'(ofs_m), 32'd31);
    rdback("R1 rptr empty", 12'h009, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule